// File: doc/BRIEF.md
# Volume Button Event Counter

This peripheral turns front-panel volume buttons (up, down, mute) into a byte that host software reads. It raises an interrupt on every button event. The byte holds identical saturating counters, one per lane. Each lane is a zero pad bit below a count field, so with the defaults the counts sit in bits 1..3 and 5..7 and bits 0 and 4 are always zero.

Software reads the byte from any of four aliased addresses. It works out the direction of the last press by comparing the value with the mid-scale default. It then writes anything to any alias, which puts every counter back to mid-scale. A mute press interrupts but moves no counter, so software sees the unchanged default. The interrupt is a level that software clears with a dedicated strobe.

Top module: `volkey_ctl`

## Requirements
- R1: After synchronous active-low reset every counter holds 4, the byte reads 0x88 and `irq` is low.
- R2: A `btn_up` pulse increments every counter by one, so 0x88 becomes 0xAA; all lanes always hold equal counts.
- R3: Counters saturate: an up press at 7 keeps the byte at 0xEE and a down press at 0 keeps it at 0x00; neither wraps.
- R4: A `btn_dn` pulse decrements every counter by one, so 0x88 becomes 0x66.
- R5: A `btn_mute` pulse leaves every counter unchanged.
- R6: `irq` rises the cycle after any button event, including one that changes no counter, and stays high until an `irq_clr` cycle with no new event; an event in the same cycle as `irq_clr` keeps it high.
- R7: Simultaneous button pulses resolve as mute over up over down, and raise one interrupt.
- R8: A write (`reg_wr` high) to any of the four aliases (addresses 0..3, that is `reg_addr[3:2]==0` with any `reg_addr[1:0]`) sets every counter to 4 (byte 0x88) on the next cycle, whatever `reg_wdata` holds; a write beats a button press in the same cycle.
- R9: With `reg_rd` high, all four aliases return the same byte, with bits 0 and 4 zero; `reg_rdata` is 0 when `reg_rd` is low or the address is outside the alias window.
- R10: A write to an address outside the alias window (`reg_addr[3:2]!=0`) changes no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_up | input | 1 | Volume-up press, single-cycle pulse |
| btn_dn | input | 1 | Volume-down press, single-cycle pulse |
| btn_mute | input | 1 | Mute press, single-cycle pulse |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data (value ignored) |
| reg_rdata | output | 8 | Read data, combinational from the counters |
| irq | output | 1 | Level interrupt |
| irq_clr | input | 1 | Interrupt clear strobe |

## Verification
Single up and down presses from mid-scale separate increment from decrement. Runs of presses into both ends separate saturation from wrap-around. Mute and combined pulses expose the priority order and whether a silent event still interrupts. Writes of zero and of all-ones through each alias, followed by reads of all four aliases, show that the data is ignored and the storage shared. Writes and reads outside the window, and reads with the strobe low, separate decoding from aliasing.

// File: rtl/volkey_pkg.sv
package volkey_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_UP   = 2'd1,
    EV_DOWN = 2'd2,
    EV_MUTE = 2'd3
  } ev_e;
endpackage

// File: rtl/volkey_arb.sv
module volkey_arb
  import volkey_pkg::*;
(
  input  logic btn_up,
  input  logic btn_dn,
  input  logic btn_mute,
  output ev_e  ev,
  output logic any_ev
);
  // Priority: mute, then up, then down (R7)
  always_comb begin
    if (btn_mute)    ev = EV_MUTE;
    else if (btn_up) ev = EV_UP;
    else if (btn_dn) ev = EV_DOWN;
    else             ev = EV_NONE;
  end

  assign any_ev = btn_up | btn_dn | btn_mute;

  always_comb begin
    if (btn_mute) p_mute_first_r7: assert (ev == EV_MUTE);
  end
endmodule

// File: rtl/volkey_satcnt.sv
module volkey_satcnt
  import volkey_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_mid,
  input  ev_e              ev,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] MAX = '1;

  function automatic logic [CNT_W-1:0] sat_next(input logic [CNT_W-1:0] c, input ev_e e);
    case (e)
      EV_UP:   return (c == MAX) ? c : c + 1'b1;
      EV_DOWN: return (c == '0)  ? c : c - 1'b1;
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= MID;
    else if (load_mid) cnt <= MID;
    else               cnt <= sat_next(cnt, ev);
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX && ev == EV_UP && !load_mid) |=> cnt == MAX);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && ev == EV_DOWN && !load_mid) |=> cnt == '0);
  p_mute_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_MUTE && !load_mid) |=> $stable(cnt));
  p_mid_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_mid |=> cnt == MID);
endmodule

// File: rtl/volkey_irq.sv
module volkey_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= set | (irq & ~clr);
  end

  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq);
endmodule

// File: rtl/volkey_ctl.sv
module volkey_ctl
  import volkey_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int LANES      = 2,
  parameter int ADDR_W     = 4,
  parameter int ALIAS_BITS = 2,
  parameter int WINDOW     = 0,
  localparam int LANE_W    = CNT_W + 1,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_up,
  input  logic              btn_dn,
  input  logic              btn_mute,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              irq_clr
);
  localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);

  function automatic logic [DATA_W-1:0] pad_mask();
    logic [DATA_W-1:0] m = '0;
    for (int l = 0; l < LANES; l++) m[l*LANE_W] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] mid_byte();
    logic [DATA_W-1:0] b = '0;
    for (int l = 0; l < LANES; l++) b[l*LANE_W +: LANE_W] = {MID, 1'b0};
    return b;
  endfunction

  localparam logic [DATA_W-1:0] PAD_MASK = pad_mask();
  localparam logic [DATA_W-1:0] MID_BYTE = mid_byte();

  ev_e  ev;
  logic any_ev;
  logic win_hit;
  logic wr_hit;
  logic [CNT_W-1:0]  cnt [LANES];
  logic [DATA_W-1:0] rd_byte;

  assign win_hit = (reg_addr >> ALIAS_BITS) == ADDR_W'(WINDOW);
  assign wr_hit  = reg_wr & win_hit;

  volkey_arb u_arb (
    .btn_up  (btn_up),
    .btn_dn  (btn_dn),
    .btn_mute(btn_mute),
    .ev      (ev),
    .any_ev  (any_ev)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    volkey_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_mid(wr_hit),
      .ev      (ev),
      .cnt     (cnt[l])
    );
    assign rd_byte[l*LANE_W +: LANE_W] = {cnt[l], 1'b0};
  end

  volkey_irq u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (any_ev),
    .clr  (irq_clr),
    .irq  (irq)
  );

  assign reg_rdata = (reg_rd && win_hit) ? rd_byte : '0;

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & PAD_MASK) == '0);
  p_lanes_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] == cnt[LANES-1]);
  p_any_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && reg_wdata != MID_BYTE) |=> (rd_byte == MID_BYTE));
  p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !win_hit && ev == EV_NONE) |=> $stable(rd_byte));
endmodule

// File: tb/sim_volkey_ctl.sv
module sim_volkey_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_up = 0, btn_dn = 0, btn_mute = 0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0, irq_clr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  int model = 4;
  bit done = 0;

  always #5 clk = ~clk;

  volkey_ctl u0 (.clk(clk), .rst_n(rst_n), .btn_up(btn_up), .btn_dn(btn_dn),
    .btn_mute(btn_mute), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .irq_clr(irq_clr));

  function automatic logic [7:0] enc(int c);
    logic [2:0] v = c[2:0];
    return {v, 1'b0, v, 1'b0};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
    reg_addr = a; reg_rd = 1; #1;
    chk(req, reg_rdata, exp);
    reg_rd = 0;
  endtask

  // one-cycle button pulse; returns at the following negedge
  task automatic press(bit u, bit d, bit m);
    @(negedge clk); btn_up = u; btn_dn = d; btn_mute = m;
    @(negedge clk); btn_up = 0; btn_dn = 0; btn_mute = 0;
    if (m) model = model;
    else if (u) model = (model == 7) ? 7 : model + 1;
    else if (d) model = (model == 0) ? 0 : model - 1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    if (a[3:2] == 0) model = 4;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1", 0, 8'h88);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_up_down();
    press(1, 0, 0); rd_chk("R2", 1, 8'hAA);
    chk("R6 irq after up", {7'b0, irq}, 8'h01);
    wr(0, 8'h00); press(0, 1, 0); rd_chk("R4", 2, 8'h66);
  endtask

  task automatic t_saturate();
    wr(3, 8'hFF);
    for (int i = 0; i < 5; i++) press(1, 0, 0);
    rd_chk("R3 top", 0, 8'hEE);
    clr_irq(); chk("R6 cleared", {7'b0, irq}, 8'h00);
    press(1, 0, 0);
    rd_chk("R3 top hold", 0, enc(model));
    chk("R6 saturated press irq", {7'b0, irq}, 8'h01);
    for (int i = 0; i < 9; i++) press(0, 1, 0);
    rd_chk("R3 bottom", 3, 8'h00);
  endtask

  task automatic t_mute();
    wr(1, 8'h5A); press(0, 1, 0); clr_irq();
    press(0, 0, 1);
    rd_chk("R5", 0, 8'h66);
    chk("R5 irq", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_priority();
    wr(0, 8'h01);
    press(1, 1, 0); rd_chk("R7 up over down", 0, 8'hAA);
    press(1, 1, 1); rd_chk("R7 mute first", 0, 8'hAA);
    chk("R7 irq", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_irq_race();
    clr_irq();
    @(negedge clk); irq_clr = 1; btn_dn = 1;
    @(negedge clk); irq_clr = 0; btn_dn = 0; model = model - 1;
    chk("R6 event beats clear", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_alias();
    wr(2, 8'h00);
    for (int a = 0; a < 4; a++) rd_chk("R9 alias", 4'(a), 8'h88);
    press(1, 0, 0);
    @(negedge clk); reg_addr = 1; reg_wr = 1; btn_up = 1;
    @(negedge clk); reg_wr = 0; btn_up = 0; model = 4;
    rd_chk("R8 write beats button", 3, 8'h88);
  endtask

  task automatic t_outside();
    press(0, 1, 0);
    wr(4'h5, 8'h00); rd_chk("R10", 0, 8'h66);
    wr(4'hC, 8'hFF); rd_chk("R10 high window", 2, 8'h66);
    rd_chk("R9 out of window read", 4'h9, 8'h00);
    reg_addr = 0; reg_rd = 0; #1;
    chk("R9 rd low", reg_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_up_down();
    t_saturate();
    t_mute();
    t_priority();
    t_irq_race();
    t_alias();
    t_outside();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule